// File: doc/BRIEF.md
# I/O Port Configuration-Space Address Decoder

This block takes one I/O port access per cycle (port number, byte count, write data and a write flag) and decides where it lands. A four-byte access to the configuration-address port (0xCF8) is served by a 32-bit register inside the block. Writes load it, and reads return its value. An access to the four-byte configuration-data window (0xCFC to 0xCFF) becomes a configuration-space physical address when the register's top bit is set. Any other legal port is passed through into the I/O physical region.

The result is registered and appears one cycle after the request. It consists of a physical address, a two-bit region code, a flag marking an internal register access, read data for internal reads, and an error flag. The error flag is raised when the incoming port number does not fit in 16 bits. The region prefixes are parameters that set distinct upper address bits.

Top module: `io_cfg_decoder`

## Requirements
- R1: After reset `outValid` is 0 and the configuration-address register holds 0, so a first four-byte read of port 0xCF8 returns 0.
- R2: A request whose port has any bit above bit 15 set gives `outErr`=1, region code 3, `outInternal`=0 and address 0, and leaves the register unchanged.
- R3: A write with byte count 4 (`reqSize`=4) to port 0xCF8 loads the register from `reqWrData`. It reports region code 2, `outInternal`=1, address 0 and read data 0.
- R4: A read with byte count 4 of port 0xCF8 reports region code 2, `outInternal`=1 and the register's current value on `outRdData`.
- R5: An access to port 0xCF8 with a byte count other than 4 is ordinary I/O (R8 address, region code 0) and leaves the register unchanged.
- R6: A port in 0xCFC..0xCFF, with register bit 31 set, gives region code 1 and address `CFG_PREFIX` | {register bits 30:2, port bits 1:0}.
- R7: A port in 0xCFC..0xCFF, with register bit 31 clear, gives region code 0 and address `IO_PREFIX` | port.
- R8: Any other 16-bit port gives region code 0 and address `IO_PREFIX` | port, with `outInternal`=0.
- R9: Every output reflects the request of the previous cycle. `outValid` equals `reqValid` one cycle earlier.
- R10: In a cycle without a request, the next cycle's outputs are all 0, and the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqPort | input | PORT_IN_W (20) | Requested port number, possibly out of range |
| reqSize | input | SIZE_W (3) | Access size in bytes |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWrData | input | DATA_W (32) | Write data |
| outValid | output | 1 | Result present |
| outAddr | output | ADDR_W (40) | Target physical address |
| outRegion | output | 2 | 0 I/O, 1 config space, 2 internal register, 3 error |
| outInternal | output | 1 | Access served by the internal register |
| outRdData | output | DATA_W (32) | Register value for an internal read |
| outErr | output | 1 | Port number exceeded 16 bits |

## Verification
The bench uses the default parameters: a 20-bit port input, a 40-bit address, the I/O prefix at bit 37 and the config prefix at bit 38. The four spare port bits make out-of-range ports reachable, so the error path can be driven together with a register-port pattern in the low bits. The separated prefixes let every region be identified from the address alone. The register is loaded with low bits 1:0 nonzero, so the reference model can show that those bits are replaced by the port bits in config addresses. The enable bit is toggled between window accesses.

// File: rtl/io_cfg_pkg.sv
package io_cfg_pkg;

  typedef enum logic [1:0] {
    RGN_IO     = 2'd0,
    RGN_CFG    = 2'd1,
    RGN_INTREG = 2'd2,
    RGN_ERR    = 2'd3
  } region_e;

  // Strobes handed from the decode control to the datapath
  typedef struct packed {
    logic accValid;
    logic errPort;
    logic cfgAddrWr;
    logic cfgAddrRd;
    logic dataWin;
  } decStrobe_t;

  localparam logic [15:0] CFG_ADDR_PORT = 16'h0CF8;
  localparam logic [15:0] CFG_DATA_BASE = 16'h0CFC;
  localparam int          CFG_REG_BYTES = 4;

endpackage

// File: rtl/io_cfg_ctrl.sv
module io_cfg_ctrl
  import io_cfg_pkg::*;
#(
  parameter int PORT_IN_W = 20,
  parameter int SIZE_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [PORT_IN_W-1:0] reqPort,
  input  logic [SIZE_W-1:0]    reqSize,
  input  logic                 reqWrite,
  output decStrobe_t           strobes
);

  localparam int PORT_W = 16;

  logic              highSet;
  logic [PORT_W-1:0] portLo;
  logic              isCfgAddr;
  logic              inWindow;

  generate
    if (PORT_IN_W > PORT_W) begin : g_wide
      assign highSet = |reqPort[PORT_IN_W-1:PORT_W];
    end else begin : g_narrow
      assign highSet = 1'b0;
    end
  endgenerate

  assign portLo    = reqPort[PORT_W-1:0];
  assign isCfgAddr = (portLo == CFG_ADDR_PORT) &&
                     (reqSize == SIZE_W'(CFG_REG_BYTES));
  assign inWindow  = (portLo[PORT_W-1:2] == CFG_DATA_BASE[PORT_W-1:2]);

  always_comb begin
    strobes           = '0;
    strobes.accValid  = reqValid;
    strobes.errPort   = reqValid && highSet;
    strobes.cfgAddrWr = reqValid && !highSet && isCfgAddr && reqWrite;
    strobes.cfgAddrRd = reqValid && !highSet && isCfgAddr && !reqWrite;
    strobes.dataWin   = reqValid && !highSet && inWindow;
  end

  // R5
  size_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != SIZE_W'(CFG_REG_BYTES)) |->
      !(strobes.cfgAddrWr || strobes.cfgAddrRd));

  // R2
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.errPort |-> !(strobes.cfgAddrWr || strobes.cfgAddrRd || strobes.dataWin));

endmodule

// File: rtl/io_cfg_datapath.sv
module io_cfg_datapath
  import io_cfg_pkg::*;
#(
  parameter int              PORT_IN_W  = 20,
  parameter int              ADDR_W     = 40,
  parameter int              DATA_W     = 32,
  parameter logic [39:0]     IO_PREFIX  = 40'h20_0000_0000,
  parameter logic [39:0]     CFG_PREFIX = 40'h40_0000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  decStrobe_t           strobes,
  input  logic [PORT_IN_W-1:0] reqPort,
  input  logic [DATA_W-1:0]    reqWrData,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outAddr,
  output logic [1:0]           outRegion,
  output logic                 outInternal,
  output logic [DATA_W-1:0]    outRdData,
  output logic                 outErr
);

  localparam logic [ADDR_W-1:0] IO_BASE  = IO_PREFIX[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CFG_BASE = CFG_PREFIX[ADDR_W-1:0];

  logic [DATA_W-1:0] cfgReg;
  logic              cfgEnable;
  logic [ADDR_W-1:0] cfgAddr;
  logic [ADDR_W-1:0] ioAddr;

  logic [ADDR_W-1:0] nAddr;
  region_e           nRegion;
  logic              nInternal;
  logic [DATA_W-1:0] nRdData;

  assign cfgEnable = cfgReg[DATA_W-1];
  assign cfgAddr   = CFG_BASE | ADDR_W'({cfgReg[DATA_W-2:2], reqPort[1:0]});
  assign ioAddr    = IO_BASE | ADDR_W'(reqPort[15:0]);

  always_comb begin
    nAddr     = '0;
    nRegion   = RGN_IO;
    nInternal = 1'b0;
    nRdData   = '0;
    if (strobes.errPort) begin
      nRegion = RGN_ERR;
    end else if (strobes.cfgAddrWr || strobes.cfgAddrRd) begin
      nRegion   = RGN_INTREG;
      nInternal = 1'b1;
      if (strobes.cfgAddrRd) nRdData = cfgReg;
    end else if (strobes.dataWin && cfgEnable) begin
      nRegion = RGN_CFG;
      nAddr   = cfgAddr;
    end else if (strobes.accValid) begin
      nAddr = ioAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (strobes.cfgAddrWr) begin
      cfgReg <= reqWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.accValid) begin
      outValid    <= 1'b0;
      outAddr     <= '0;
      outRegion   <= 2'd0;
      outInternal <= 1'b0;
      outRdData   <= '0;
      outErr      <= 1'b0;
    end else begin
      outValid    <= 1'b1;
      outAddr     <= nAddr;
      outRegion   <= nRegion;
      outInternal <= nInternal;
      outRdData   <= nRdData;
      outErr      <= strobes.errPort;
    end
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accValid |=> outValid);

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accValid |=> (!outValid && !outInternal && !outErr));

  // R3
  reg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cfgAddrWr |=> (cfgReg == $past(reqWrData)));

  // R10
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cfgAddrWr |=> $stable(cfgReg));

  // R6
  cfg_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataWin && !strobes.errPort) |=>
      ((outRegion == 2'(RGN_CFG)) == $past(cfgEnable)));

  // R2
  err_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> (outRegion == 2'(RGN_ERR) && !outInternal));

endmodule

// File: rtl/io_cfg_decoder.sv
module io_cfg_decoder
  import io_cfg_pkg::*;
#(
  parameter int          PORT_IN_W  = 20,
  parameter int          SIZE_W     = 3,
  parameter int          ADDR_W     = 40,
  parameter int          DATA_W     = 32,
  parameter logic [39:0] IO_PREFIX  = 40'h20_0000_0000,
  parameter logic [39:0] CFG_PREFIX = 40'h40_0000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [PORT_IN_W-1:0] reqPort,
  input  logic [SIZE_W-1:0]    reqSize,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    reqWrData,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outAddr,
  output logic [1:0]           outRegion,
  output logic                 outInternal,
  output logic [DATA_W-1:0]    outRdData,
  output logic                 outErr
);

  decStrobe_t strobes;

  io_cfg_ctrl #(
    .PORT_IN_W (PORT_IN_W),
    .SIZE_W    (SIZE_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqPort  (reqPort),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .strobes  (strobes)
  );

  io_cfg_datapath #(
    .PORT_IN_W  (PORT_IN_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .IO_PREFIX  (IO_PREFIX),
    .CFG_PREFIX (CFG_PREFIX)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqPort     (reqPort),
    .reqWrData   (reqWrData),
    .outValid    (outValid),
    .outAddr     (outAddr),
    .outRegion   (outRegion),
    .outInternal (outInternal),
    .outRdData   (outRdData),
    .outErr      (outErr)
  );

endmodule

// File: tb/io_cfg_decoder_tb.sv
`timescale 1ns/1ps
module io_cfg_decoder_tb_top;

  localparam logic [39:0] IO_PFX  = 40'h20_0000_0000;
  localparam logic [39:0] CFG_PFX = 40'h40_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqPort = '0;
  logic [2:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWrData = '0;
  logic        outValid;
  logic [39:0] outAddr;
  logic [1:0]  outRegion;
  logic        outInternal;
  logic [31:0] outRdData;
  logic        outErr;

  int checks = 0;
  int errors = 0;
  bit cmpOn  = 1'b0;

  // reference model state
  logic [31:0] mReg = '0;
  logic        eValid = 1'b0;
  logic [39:0] eAddr = '0;
  logic [1:0]  eRegion = '0;
  logic        eInt = 1'b0;
  logic [31:0] eRd = '0;
  logic        eErr = 1'b0;
  string       eTag = "R10";

  always #2.5 clk = ~clk;

  io_cfg_decoder dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWrData(reqWrData),
    .outValid(outValid), .outAddr(outAddr), .outRegion(outRegion),
    .outInternal(outInternal), .outRdData(outRdData), .outErr(outErr)
  );

  // behavioural model, one result per clock
  always @(posedge clk) begin
    eValid = 0; eAddr = '0; eRegion = 0; eInt = 0; eRd = '0; eErr = 0;
    if (!rstN) begin
      mReg = '0; eTag = "R1";
    end else if (!reqValid) begin
      eTag = "R10";
    end else begin
      eValid = 1;
      if (reqPort[19:16] != 0) begin
        eErr = 1; eRegion = 3; eTag = "R2";
      end else if (reqPort[15:0] == 16'h0CF8 && reqSize == 3'd4) begin
        eInt = 1; eRegion = 2;
        if (reqWrite) begin mReg = reqWrData; eTag = "R3"; end
        else begin eRd = mReg; eTag = "R4"; end
      end else if (reqPort[15:0] >= 16'h0CFC && reqPort[15:0] <= 16'h0CFF && mReg[31]) begin
        eRegion = 1;
        eAddr = CFG_PFX | {9'd0, mReg[30:2], reqPort[1:0]};
        eTag = "R6";
      end else begin
        eAddr = IO_PFX | {24'd0, reqPort[15:0]};
        if (reqPort[15:0] >= 16'h0CFC && reqPort[15:0] <= 16'h0CFF) eTag = "R7";
        else if (reqPort[15:0] == 16'h0CF8) eTag = "R5";
        else eTag = "R8";
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      checks++;
      if (outValid !== eValid || outAddr !== eAddr || outRegion !== eRegion ||
          outInternal !== eInt || outRdData !== eRd || outErr !== eErr) begin
        errors++;
        $display("FAIL %s (R9 timing): got v=%0b a=%h r=%0d i=%0b d=%h e=%0b exp v=%0b a=%h r=%0d i=%0b d=%h e=%0b",
          eTag, outValid, outAddr, outRegion, outInternal, outRdData, outErr,
          eValid, eAddr, eRegion, eInt, eRd, eErr);
      end
    end
  end

  task automatic acc(input logic [19:0] p, input logic [2:0] s,
                     input logic w, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqPort = p; reqSize = s; reqWrite = w; reqWrData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 0; reqPort = '0; reqSize = '0; reqWrite = 0; reqWrData = '0;
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state seen at the ports
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got outValid=%0b exp 0", outValid);
    end
    cmpOn = 1;
    acc(20'h00CF8, 3'd4, 0, '0);            // R1 / R4: reads 0
    acc(20'h00CF8, 3'd4, 1, 32'h8012_3457); // R3
    acc(20'h00CF8, 3'd4, 0, '0);            // R4
    for (int k = 0; k < 4; k++) acc(20'h00CFC + 20'(k), 3'd1, k[0], 32'hFFFF_FFFF); // R6
    acc(20'h00CF8, 3'd2, 1, 32'h0000_0000); // R5: not the register
    acc(20'h00CF8, 3'd1, 0, '0);            // R5
    acc(20'h00CF8, 3'd4, 0, '0);            // R5: register unchanged
    acc(20'h10CF8, 3'd4, 1, 32'h1111_1111); // R2
    acc(20'hF0CFC, 3'd4, 0, '0);            // R2
    acc(20'h00CF8, 3'd4, 0, '0);            // R2: register unchanged
    idle(3);                                // R10
    acc(20'h00CF8, 3'd4, 0, '0);            // R10: register kept
    acc(20'h00CF8, 3'd4, 1, 32'h0000_ABCD); // R3
    for (int k = 0; k < 4; k++) acc(20'h00CFC + 20'(k), 3'd4, 0, '0); // R7
    acc(20'h00080, 3'd1, 0, '0);            // R8
    acc(20'h00CF7, 3'd4, 1, 32'h5);         // R8
    acc(20'h00D00, 3'd2, 0, '0);            // R8
    acc(20'h0FFFF, 3'd4, 0, '0);            // R8
    acc(20'h00CFB, 3'd4, 0, '0);            // R8
    acc(20'h00CF8, 3'd4, 1, 32'hFFFF_FFFF); // R3
    acc(20'h00CFE, 3'd2, 0, '0);            // R6 all-ones offset
    idle(1);
    acc(20'h00CFD, 3'd4, 1, 32'h0);         // R6 after idle
    idle(2);
    cmpOn = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule